// File: doc/BRIEF.md
# Two-Way Write-Back Cache Level

This block is one level of a cache hierarchy, organised as a two-way set-associative array. Every row holds two ways, and each way keeps its own tag, valid flag, dirty flag and data block. Each row also keeps one replacement bit that names the way to evict next. An upstream client presents load and store requests one at a time. The client holds each request steady until the block pulses `req_done`. A hit completes combinationally in the cycle it is presented, and the lookup state is updated at the following clock edge.

Stores use write-back. A store changes only this level's copy and marks that way dirty, and nothing goes downstream at that moment. On a miss the block chooses a victim way. If the victim is dirty, the block first writes the victim back to the level directly below and waits for that write to be acknowledged. It then reads the missing block from below and installs it. A clean victim is dropped without any downstream write. The level below receives each write-back as a modified block and must treat its own copy as dirty. Store misses allocate: the block is fetched, and the stored word is merged in when the request is replayed as a hit.

Top module: `wb2c_cache`

## Requirements
- R1: After reset every way is invalid, clean and unreferenced. The first access to any row therefore fetches from below, and no write-back is issued.
- R2: A load that hits returns the stored word in the same cycle it is presented (`req_done`=1) and issues no downstream read or write.
- R3: A store that hits changes only the addressed word in this level. It issues no downstream traffic and marks the way dirty.
- R4: On a miss, an invalid way of the row is filled before any valid way is evicted. At most one way of a row ever matches a given tag.
- R5: When both ways are valid, a miss replaces the way that was not the most recent one to hit.
- R6: Evicting a dirty way issues one write-back of the whole victim block, at the victim's own block address. The write-back is acknowledged before the fill read starts, and the two requests are never raised together.
- R7: Evicting a clean way issues no write-back.
- R8: A store miss fetches the block, merges the store word into it and leaves the way valid and dirty. The other words of the block keep the values fetched from below.
- R9: A miss stalls the request. With a downstream acknowledge that arrives on the second cycle of each request, `req_done` comes 3 cycles after presentation for a fill only and 5 cycles after for a write-back plus fill. Each downstream request holds its address until it is acknowledged.
- R10: The address splits as follows: byte-in-word in bit 0 (must be 0), word-in-block in bits [2:1], row index in bits [4:3] and tag in bits [11:5]. Downstream addresses are block aligned, with the low 3 bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Upstream request present, held until `req_done` |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 12 | Byte address of the word |
| req_wdata | input | 16 | Store data |
| req_done | output | 1 | Request completes this cycle |
| req_rdata | output | 16 | Load data, valid with `req_done` |
| mem_rd_req | output | 1 | Fill read request to the level below |
| mem_rd_addr | output | 12 | Block-aligned fill address |
| mem_rd_ack | input | 1 | Fill data present |
| mem_rd_data | input | 64 | Fill block |
| mem_wr_req | output | 1 | Write-back request to the level below |
| mem_wr_addr | output | 12 | Block-aligned write-back address |
| mem_wr_data | output | 64 | Victim block |
| mem_wr_ack | input | 1 | Write-back accepted |

## Verification
The hardest case to reach is a dirty victim that is also the least recently used way. Getting there needs a row with both ways valid, a store hit on one way, and then a hit on the other way so that the dirty way becomes the replacement choice. The vector table walks two rows through exactly that history. Afterwards it reloads the evicted block, which shows through the ports that the written-back data reached the model below. A final directed pass dirties a way, resets the block, and confirms that no write-back appears afterwards.

// File: rtl/wb2c_pkg.sv
package wb2c_pkg;
   typedef enum logic [1:0] {
      CS_IDLE  = 2'd0,
      CS_EVICT = 2'd1,
      CS_FETCH = 2'd2
   } ctl_state_e;
endpackage

// File: rtl/wb2c_meta.sv
module wb2c_meta #(
   parameter int ROWS  = 4,
   parameter int TAG_W = 7,
   localparam int IDX_W = $clog2(ROWS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic [TAG_W-1:0] lk_tag,
   output logic             hit,
   output logic             hit_way,
   output logic             vict_way,
   input  logic             sel_way,
   output logic             sel_valid,
   output logic             sel_dirty,
   output logic [TAG_W-1:0] sel_tag,
   input  logic             touch_en,
   input  logic             touch_way,
   input  logic             touch_dirty,
   input  logic             fill_en,
   input  logic             fill_way,
   input  logic [TAG_W-1:0] fill_tag
);
   logic [TAG_W-1:0] tag_q [ROWS][2];
   logic [1:0]       val_q [ROWS];
   logic [1:0]       dty_q [ROWS];
   logic             lru_q [ROWS];
   logic [1:0]       hit_vec;

   for (genvar w = 0; w < 2; w++) begin : g_way_cmp
      assign hit_vec[w] = val_q[idx][w] && (tag_q[idx][w] == lk_tag);
   end

   assign hit     = |hit_vec;
   assign hit_way = hit_vec[1];

   // invalid ways are taken first, then the replacement bit decides
   always_comb begin
      if (!val_q[idx][0])      vict_way = 1'b0;
      else if (!val_q[idx][1]) vict_way = 1'b1;
      else                     vict_way = lru_q[idx];
   end

   assign sel_valid = val_q[idx][sel_way];
   assign sel_dirty = dty_q[idx][sel_way];
   assign sel_tag   = tag_q[idx][sel_way];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < ROWS; r++) begin
            val_q[r] <= '0;
            dty_q[r] <= '0;
            lru_q[r] <= 1'b0;
         end
      end else begin
         if (touch_en) begin
            lru_q[idx] <= ~touch_way;
            if (touch_dirty) dty_q[idx][touch_way] <= 1'b1;
         end
         if (fill_en) begin
            val_q[idx][fill_way] <= 1'b1;
            dty_q[idx][fill_way] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) tag_q[idx][fill_way] <= fill_tag;
   end

   // R4
   hit_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));
endmodule

// File: rtl/wb2c_data.sv
module wb2c_data #(
   parameter int ROWS    = 4,
   parameter int BLOCK_W = 64,
   parameter int WORD_W  = 16,
   localparam int IDX_W  = $clog2(ROWS),
   localparam int WSEL_W = $clog2(BLOCK_W / WORD_W)
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  idx,
   input  logic              a_way,
   output logic [BLOCK_W-1:0] a_blk,
   input  logic              b_way,
   output logic [BLOCK_W-1:0] b_blk,
   input  logic              wr_en,
   input  logic              wr_way,
   input  logic [WSEL_W-1:0] wr_sel,
   input  logic [WORD_W-1:0] wr_word,
   input  logic              fill_en,
   input  logic              fill_way,
   input  logic [BLOCK_W-1:0] fill_blk
);
   logic [BLOCK_W-1:0] blk_q [ROWS][2];

   assign a_blk = blk_q[idx][a_way];
   assign b_blk = blk_q[idx][b_way];

   always_ff @(posedge clk) begin
      if (fill_en)
         blk_q[idx][fill_way] <= fill_blk;
      else if (wr_en)
         blk_q[idx][wr_way][wr_sel*WORD_W +: WORD_W] <= wr_word;
   end
endmodule

// File: rtl/wb2c_cache.sv
module wb2c_cache
   import wb2c_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int BLOCK_BYTES = 8,
   parameter int ROWS        = 4,
   parameter int WORD_W      = 16,
   localparam int OFF_W   = $clog2(BLOCK_BYTES),
   localparam int IDX_W   = $clog2(ROWS),
   localparam int TAG_W   = ADDR_W - OFF_W - IDX_W,
   localparam int BLOCK_W = BLOCK_BYTES * 8,
   localparam int WORDS   = BLOCK_W / WORD_W,
   localparam int WSEL_W  = $clog2(WORDS),
   localparam int BSEL_W  = OFF_W - WSEL_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [WORD_W-1:0]  req_wdata,
   output logic               req_done,
   output logic [WORD_W-1:0]  req_rdata,
   output logic               mem_rd_req,
   output logic [ADDR_W-1:0]  mem_rd_addr,
   input  logic               mem_rd_ack,
   input  logic [BLOCK_W-1:0] mem_rd_data,
   output logic               mem_wr_req,
   output logic [ADDR_W-1:0]  mem_wr_addr,
   output logic [BLOCK_W-1:0] mem_wr_data,
   input  logic               mem_wr_ack
);
   initial begin
      prm_block_chk: assert ((1 << OFF_W) == BLOCK_BYTES && WORDS >= 2)
         else $error("block size must be a power of two holding two or more words");
      prm_rows_chk: assert ((1 << IDX_W) == ROWS && ROWS >= 2)
         else $error("row count must be a power of two, at least 2");
      prm_tag_chk: assert (TAG_W >= 1 && WORD_W % 8 == 0)
         else $error("address too narrow or word not whole bytes");
   end

   ctl_state_e state_q;
   logic       vict_q;

   logic [TAG_W-1:0]  lk_tag;
   logic [IDX_W-1:0]  lk_idx;
   logic [WSEL_W-1:0] lk_wsel;
   logic              hit, hit_way, vict_way, sel_way, sel_valid, sel_dirty;
   logic [TAG_W-1:0]  sel_tag;
   logic              hit_now, fill_now;
   logic [BLOCK_W-1:0] hit_blk, vict_blk;

   assign lk_tag  = req_addr[ADDR_W-1 -: TAG_W];
   assign lk_idx  = req_addr[OFF_W +: IDX_W];
   assign lk_wsel = req_addr[BSEL_W +: WSEL_W];

   assign sel_way  = (state_q == CS_IDLE) ? vict_way : vict_q;
   assign hit_now  = req_valid && hit && (state_q == CS_IDLE);
   assign fill_now = (state_q == CS_FETCH) && mem_rd_ack;

   wb2c_meta #(.ROWS(ROWS), .TAG_W(TAG_W)) meta_i (
      .clk, .rst_n,
      .idx        (lk_idx),
      .lk_tag     (lk_tag),
      .hit        (hit),
      .hit_way    (hit_way),
      .vict_way   (vict_way),
      .sel_way    (sel_way),
      .sel_valid  (sel_valid),
      .sel_dirty  (sel_dirty),
      .sel_tag    (sel_tag),
      .touch_en   (hit_now),
      .touch_way  (hit_way),
      .touch_dirty(req_write),
      .fill_en    (fill_now),
      .fill_way   (vict_q),
      .fill_tag   (lk_tag)
   );

   wb2c_data #(.ROWS(ROWS), .BLOCK_W(BLOCK_W), .WORD_W(WORD_W)) data_i (
      .clk,
      .idx      (lk_idx),
      .a_way    (hit_way),
      .a_blk    (hit_blk),
      .b_way    (sel_way),
      .b_blk    (vict_blk),
      .wr_en    (hit_now && req_write),
      .wr_way   (hit_way),
      .wr_sel   (lk_wsel),
      .wr_word  (req_wdata),
      .fill_en  (fill_now),
      .fill_way (vict_q),
      .fill_blk (mem_rd_data)
   );

   assign req_done  = hit_now;
   assign req_rdata = hit_blk[lk_wsel*WORD_W +: WORD_W];

   assign mem_wr_req  = (state_q == CS_EVICT);
   assign mem_wr_addr = {sel_tag, lk_idx, {OFF_W{1'b0}}};
   assign mem_wr_data = vict_blk;
   assign mem_rd_req  = (state_q == CS_FETCH);
   assign mem_rd_addr = {lk_tag, lk_idx, {OFF_W{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CS_IDLE;
         vict_q  <= 1'b0;
      end else begin
         unique case (state_q)
            CS_IDLE: if (req_valid && !hit) begin
               vict_q  <= vict_way;
               state_q <= (sel_valid && sel_dirty) ? CS_EVICT : CS_FETCH;
            end
            CS_EVICT: if (mem_wr_ack) state_q <= CS_FETCH;
            CS_FETCH: if (mem_rd_ack) state_q <= CS_IDLE;
            default:  state_q <= CS_IDLE;
         endcase
      end
   end

   // R6
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_req && mem_wr_req));

   // R6
   wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_req && mem_wr_ack) |=> mem_rd_req);

   // R9
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_req && !mem_wr_ack) |=> (mem_wr_req && $stable(mem_wr_addr)));

   // R9
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));

   if (BSEL_W > 0) begin : g_align
      // R10
      word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid |-> (req_addr[BSEL_W-1:0] == '0));
   end
endmodule

// File: tb/wb2c_cache_tb.sv
`timescale 1ns/1ps
module wb2c_cache_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [11:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        req_done;
   logic [15:0] req_rdata;
   logic        mem_rd_req, mem_wr_req;
   logic [11:0] mem_rd_addr, mem_wr_addr;
   logic        mem_rd_ack = 1'b0, mem_wr_ack = 1'b0;
   logic [63:0] mem_rd_data = '0;
   logic [63:0] mem_wr_data;

   always #2.5 clk = ~clk;

   wb2c_cache dut_i (.*);

   int checks = 0, failures = 0;
   logic [63:0] mem_blk [512];
   logic [15:0] gold [2048];
   int wb_cnt = 0, fill_cnt = 0, overlap = 0;
   logic [11:0] last_wb_addr = '0, last_rd_addr = '0;
   int wcnt = 0, rcnt = 0;

   function automatic logic [15:0] initv(int wa);
      return 16'hA500 ^ 16'(wa);
   endfunction

   function automatic logic [11:0] ad(int t, int i, int w);
      return 12'((t << 5) | (i << 3) | (w << 1));
   endfunction

   // model of the level below: acknowledge on the second cycle of a request
   always @(negedge clk) begin
      if (mem_rd_req && mem_wr_req) overlap++;
      if (mem_wr_req && !mem_wr_ack) begin
         if (wcnt == 1) begin
            mem_wr_ack = 1'b1; wcnt = 0; wb_cnt++;
            last_wb_addr = mem_wr_addr;
            mem_blk[mem_wr_addr >> 3] = mem_wr_data;
         end else wcnt++;
      end else mem_wr_ack = 1'b0;
      if (mem_rd_req && !mem_rd_ack) begin
         if (rcnt == 1) begin
            mem_rd_ack = 1'b1; rcnt = 0; fill_cnt++;
            last_rd_addr = mem_rd_addr;
            mem_rd_data = mem_blk[mem_rd_addr >> 3];
         end else rcnt++;
      end else mem_rd_ack = 1'b0;
   end

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_req(input logic wr, input logic [11:0] a, input logic [15:0] d,
                         output logic [15:0] rd, output int lat);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      lat = 0;
      #1;
      while (!req_done && lat < 100) begin
         @(negedge clk); #1; lat++;
      end
      rd = req_rdata;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      if (wr) gold[a >> 1] = d;
   endtask

   // {write, addr, wdata, exp_wb, exp_fill, wb_addr}
   localparam int NV = 13;
   localparam logic [42:0] VEC [NV] = '{
      {1'b0, ad(1,0,0), 16'h0,    1'b0, 1'b1, 12'h0},
      {1'b0, ad(2,0,1), 16'h0,    1'b0, 1'b1, 12'h0},
      {1'b0, ad(1,0,2), 16'h0,    1'b0, 1'b0, 12'h0},
      {1'b1, ad(1,0,3), 16'h1234, 1'b0, 1'b0, 12'h0},
      {1'b0, ad(3,0,0), 16'h0,    1'b0, 1'b1, 12'h0},
      {1'b0, ad(2,0,1), 16'h0,    1'b1, 1'b1, ad(1,0,0)},
      {1'b0, ad(1,0,3), 16'h0,    1'b0, 1'b1, 12'h0},
      {1'b1, ad(5,1,2), 16'hBEEF, 1'b0, 1'b1, 12'h0},
      {1'b0, ad(5,1,2), 16'h0,    1'b0, 1'b0, 12'h0},
      {1'b0, ad(5,1,0), 16'h0,    1'b0, 1'b0, 12'h0},
      {1'b0, ad(6,1,1), 16'h0,    1'b0, 1'b1, 12'h0},
      {1'b0, ad(7,1,3), 16'h0,    1'b1, 1'b1, ad(5,1,0)},
      {1'b0, ad(5,1,2), 16'h0,    1'b0, 1'b1, 12'h0}
   };

   initial begin
      #150000;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [15:0] rd;
      int lat, wb0, f0;
      for (int b = 0; b < 512; b++)
         for (int w = 0; w < 4; w++) begin
            mem_blk[b][w*16 +: 16] = initv(b*4 + w);
            gold[b*4 + w] = initv(b*4 + w);
         end
      repeat (3) @(negedge clk);
      // R1 reset state at the ports
      check("R1 reset done", {63'b0, req_done}, 64'd0);
      check("R1 reset mem requests", {62'b0, mem_rd_req, mem_wr_req}, 64'd0);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         logic        wr, ewb, efl;
         logic [11:0] a, wba;
         logic [15:0] d;
         {wr, a, d, ewb, efl, wba} = VEC[v];
         wb0 = wb_cnt; f0 = fill_cnt;
         do_req(wr, a, d, rd, lat);
         if (!wr) check($sformatf("R2/R8 load data vec %0d", v), {48'b0, rd}, {48'b0, gold[a >> 1]});
         check($sformatf("R3/R6/R7 write-back count vec %0d", v), 64'(wb_cnt - wb0), {63'b0, ewb});
         check($sformatf("R4/R5 fill count vec %0d", v), 64'(fill_cnt - f0), {63'b0, efl});
         if (ewb) check($sformatf("R6 write-back address vec %0d", v), {52'b0, last_wb_addr}, {52'b0, wba});
         if (efl) check($sformatf("R10 fill address vec %0d", v), {52'b0, last_rd_addr}, {52'b0, a[11:3], 3'b000});
         check($sformatf("R9 latency vec %0d", v), 64'(lat), 64'(efl ? (ewb ? 5 : 3) : 0));
      end
      check("R6 fill never overlaps write-back", 64'(overlap), 64'd0);
      // R8 merged block pushed down: store word plus fetched neighbours
      check("R8 merged word below", {48'b0, mem_blk[ad(5,1,0) >> 3][2*16 +: 16]}, 64'h0BEEF);
      check("R8 fetched word kept", {48'b0, mem_blk[ad(5,1,0) >> 3][0 +: 16]}, {48'b0, initv(ad(5,1,0) >> 1)});
      check("R3 dirty word not forwarded", {48'b0, mem_blk[ad(7,1,0) >> 3][0 +: 16]}, {48'b0, initv(ad(7,1,0) >> 1)});

      // R1 directed: dirty a way, reset, then no write-back may follow
      do_req(1'b1, ad(7,1,0), 16'h5A5A, rd, lat);
      check("R3 store hit latency", 64'(lat), 64'd0);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      wb0 = wb_cnt; f0 = fill_cnt;
      gold[ad(7,1,0) >> 1] = initv(ad(7,1,0) >> 1);
      do_req(1'b0, ad(9,1,0), 16'h0, rd, lat);
      do_req(1'b0, ad(10,1,0), 16'h0, rd, lat);
      do_req(1'b0, ad(7,1,0), 16'h0, rd, lat);
      check("R1 no write-back after reset", 64'(wb_cnt - wb0), 64'd0);
      check("R1 every access fetched after reset", 64'(fill_cnt - f0), 64'd3);
      check("R1 pre-reset store lost", {48'b0, rd}, {48'b0, initv(ad(7,1,0) >> 1)});

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule